// File: doc/BRIEF.md
# Medium-Rate Infrared Bit Clock Generator

This block turns a 48 MHz system clock into the bit timing for a medium-rate infrared link. It runs at either 1.152 Mbit/s or 0.576 Mbit/s. At these rates the ideal bit period is not a whole number of clocks. The block therefore steps through a repeating three-entry list of period lengths, so the average rate stays within ±0.1 % of nominal. At the fast rate the lengths are 42, 41 and 42 clocks. At the slow rate they are 84, 83 and 83 clocks, which averages 83.33.

The framing logic pulses `frame_anchor` on the first start flag, whether that flag is being sent or has just been seen. This pulse resets the period list to its first entry, and timing runs from that point. The framing logic pulses `frame_stop` when the stop flag has been sent or detected, and the generator then goes back to idle.

In transmit mode the block does two things:
- It marks each bit boundary with `bit_strobe`.
- It gates `ir_pulse` for about a quarter of the bit period on zero bits.

In receive mode it marks the middle of each bit with `sample_strobe`. When `enable` is low, everything is cleared.

Top module: `mir_bit_clock`

## Requirements
- R1: While `enable` is low, `active`, `bit_strobe`, `ir_pulse` and `sample_strobe` are 0 and the period list returns to its first entry. Raising `enable` alone does not start timing; a later anchor starts again at period length index 0.
- R2: With `rate_slow`=0, bit periods after an anchor last 42, 41, 42 clocks and repeat in that order.
- R3: With `rate_slow`=1, bit periods after an anchor last 84, 83, 83 clocks and repeat in that order.
- R4: An anchor pulse on clock edge E makes `active` high, and in transmit mode gives `bit_strobe` in the cycle that follows E (offset 0 of the first bit).
- R5: In transmit mode (`tx_mode`=1), `ir_pulse` is high only for a bit whose `tx_bit` at its boundary is 0. It is high for offsets 0 up to PW-1 within that bit, where PW is 10 at the fast rate and 21 at the slow rate. A bit whose `tx_bit` is 1 produces no pulse.
- R6: In receive mode (`tx_mode`=0), `sample_strobe` is high for one clock at offset floor(L/2) of each bit of length L, which is 21, 20, 42 or 41. `bit_strobe` and `ir_pulse` stay 0 in this mode.
- R7: A stop pulse on an edge leaves `active` low and all strobes 0 from the next cycle onward. Stop wins over an anchor given on the same edge.
- R8: An anchor while timing is running restarts the bit at offset 0 and returns the period list to its first entry.
- R9: `active` is high from the cycle after an anchor until a stop or the loss of `enable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Generator enable; low forces idle |
| rate_slow | input | 1 | 0 = 1.152 Mbit/s, 1 = 0.576 Mbit/s; change only while idle |
| tx_mode | input | 1 | 1 = transmit timing, 0 = receive timing |
| frame_anchor | input | 1 | One-cycle pulse at the first start flag |
| frame_stop | input | 1 | One-cycle pulse when the stop flag is sent or seen |
| tx_bit | input | 1 | Line bit value, sampled at each bit boundary |
| active | output | 1 | Bit timing is running |
| bit_strobe | output | 1 | Transmit bit boundary, one clock wide |
| ir_pulse | output | 1 | Infrared pulse gate for zero bits |
| sample_strobe | output | 1 | Receive mid-bit sampling strobe |

## Verification
Every output is decoded combinationally from registered state.

**Anchor and stop.** The effect of an anchor or stop on an edge shows up at the very next sampling point. The first `bit_strobe` therefore falls on cycle 0 after the anchor edge.

**Strobes and pulses.** Each later strobe is due at the running sum of the period lengths, counted from that cycle. The pulse gate reflects `tx_bit` in the same cycle it is driven, at offset 0.

**How the bench samples.** Inputs are driven on the falling edge and outputs are sampled one time unit later. The bench keeps its own offset, period-index and bit counters, advanced once per clock, and compares all four outputs against them on every cycle.

// File: rtl/mir_clk_pkg.sv
// Package: shared constants and types for the medium-rate infrared bit clock.
// Assumes a three-entry period list in every rate mode.
package mir_clk_pkg;
    localparam int NUM_PHASES = 3;
    localparam int PHASE_W    = $clog2(NUM_PHASES);

    typedef logic [PHASE_W-1:0] phase_t;

    // Next index in the repeating period list.
    function automatic phase_t next_phase(input phase_t cur);
        return (int'(cur) == NUM_PHASES - 1) ? phase_t'(0) : phase_t'(cur + 1'b1);
    endfunction
endpackage

// File: rtl/mir_phase_seq.sv
// Module: holds the position in the repeating period-length list and
// returns the length of the current bit for the selected rate.
// Assumes: rate_slow is stable while timing runs; clear wins over restart,
// and restart wins over advance.
module mir_phase_seq
    import mir_clk_pkg::*;
#(
    parameter int                    CNT_W      = 7,
    parameter int                    FAST_BASE  = 41,
    parameter logic [NUM_PHASES-1:0] FAST_EXTRA = 3'b101,
    parameter int                    SLOW_BASE  = 83,
    parameter logic [NUM_PHASES-1:0] SLOW_EXTRA = 3'b001
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             restart,
    input  logic             advance,
    input  logic             rate_slow,
    output phase_t           phase,
    output logic [CNT_W-1:0] period_len
);
    logic [CNT_W-1:0] fast_len [NUM_PHASES];
    logic [CNT_W-1:0] slow_len [NUM_PHASES];

    // Build the per-entry length tables from base length plus extra-clock mask.
    for (genvar g = 0; g < NUM_PHASES; g++) begin : g_len
        assign fast_len[g] = CNT_W'(FAST_BASE + int'(FAST_EXTRA[g]));
        assign slow_len[g] = CNT_W'(SLOW_BASE + int'(SLOW_EXTRA[g]));
    end

    // Select the current bit length for the chosen rate.
    always_comb begin
        period_len = rate_slow ? slow_len[phase] : fast_len[phase];
    end

    // Step the list position; return to the first entry on clear or restart.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || restart) begin
            phase <= '0;
        end else if (advance) begin
            phase <= next_phase(phase);
        end
    end

    // R2: the list position never leaves the valid range.
    p_phase_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(phase) < NUM_PHASES);

    // R2: the position only moves on a bit wrap.
    p_phase_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !restart && !advance) |=> $stable(phase));

    // R8: an anchor returns the list to its first entry.
    p_phase_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (phase == '0));
endmodule

// File: rtl/mir_bit_timer.sv
// Module: counts clocks within the current bit and tracks whether timing runs.
// Assumes period_len is at least 2 and is stable within a bit.
// Priority of controls: disable, then stop, then anchor, then counting.
module mir_bit_timer #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             anchor,
    input  logic             stop,
    input  logic [CNT_W-1:0] period_len,
    output logic             active,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    logic last_clk;

    // Flag the final clock of the current bit.
    always_comb begin
        last_clk = (cnt == (period_len - 1'b1));
        wrap     = active && last_clk;
    end

    // Run the in-bit counter and the running flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || stop) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (anchor) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (active) begin
            cnt <= last_clk ? '0 : cnt + 1'b1;
        end
    end

    // R1: dropping enable forces idle with the counter cleared.
    p_disable_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!active && cnt == '0));

    // R4: an accepted anchor starts a bit at offset zero.
    p_anchor_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && anchor && !stop) |=> (active && cnt == '0));

    // R7: stop halts timing on the next cycle.
    p_stop_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && stop) |=> !active);

    // R2: the counter stays inside the current bit length.
    p_cnt_in_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt < period_len));

    // R2: after the final clock a new bit starts at offset zero.
    p_wrap_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && enable && !stop && !anchor) |=> (active && cnt == '0));
endmodule

// File: rtl/mir_pulse_gen.sv
// Module: decodes the in-bit offset into the transmit boundary strobe,
// the quarter-width infrared pulse gate and the receive mid-bit strobe.
// Assumes tx_bit is valid in the cycle of each bit boundary (offset 0).
module mir_pulse_gen #(
    parameter int CNT_W   = 7,
    parameter int FAST_PW = 10,
    parameter int SLOW_PW = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             tx_mode,
    input  logic             rate_slow,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] period_len,
    input  logic             tx_bit,
    output logic             bit_strobe,
    output logic             ir_pulse,
    output logic             sample_strobe
);
    localparam logic [CNT_W-1:0] FAST_PW_C = CNT_W'(FAST_PW);
    localparam logic [CNT_W-1:0] SLOW_PW_C = CNT_W'(SLOW_PW);

    logic             at_boundary;
    logic             zero_now;
    logic             zero_q;
    logic [CNT_W-1:0] pw_len;

    // Decode the boundary, the bit value for this bit, and the pulse length.
    always_comb begin
        at_boundary = active && (cnt == '0);
        zero_now    = at_boundary ? !tx_bit : zero_q;
        pw_len      = rate_slow ? SLOW_PW_C : FAST_PW_C;
    end

    // Hold the zero-bit flag captured at the boundary for the rest of the bit.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            zero_q <= 1'b0;
        end else begin
            zero_q <= zero_now;
        end
    end

    // Drive the three timing outputs for the selected direction.
    always_comb begin
        bit_strobe    = tx_mode && at_boundary;
        ir_pulse      = tx_mode && active && zero_now && (cnt < pw_len);
        sample_strobe = !tx_mode && active && (cnt == (period_len >> 1));
    end

    // R5: a pulse can only begin at a bit boundary.
    p_pulse_rise_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ir_pulse) |-> bit_strobe);

    // R5: no pulse extends past the pulse width.
    p_pulse_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ir_pulse |-> (cnt < pw_len));

    // R6: receive mode never drives transmit outputs.
    p_rx_quiet_tx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_mode |-> (!bit_strobe && !ir_pulse));
endmodule

// File: rtl/mir_bit_clock.sv
// Module: top of the medium-rate infrared bit clock generator.
// Builds a fractional bit period from a repeating list of whole-clock lengths,
// anchored on the first start flag and halted at the stop flag.
// Assumes a 48 MHz clock and single-cycle anchor and stop pulses.
module mir_bit_clock
    import mir_clk_pkg::*;
#(
    parameter int                    FAST_BASE  = 41,
    parameter logic [NUM_PHASES-1:0] FAST_EXTRA = 3'b101,
    parameter int                    SLOW_BASE  = 83,
    parameter logic [NUM_PHASES-1:0] SLOW_EXTRA = 3'b001,
    parameter int                    FAST_PW    = 10,
    parameter int                    SLOW_PW    = 21
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic rate_slow,
    input  logic tx_mode,
    input  logic frame_anchor,
    input  logic frame_stop,
    input  logic tx_bit,
    output logic active,
    output logic bit_strobe,
    output logic ir_pulse,
    output logic sample_strobe
);
    localparam int MAX_LEN = ((SLOW_BASE > FAST_BASE) ? SLOW_BASE : FAST_BASE) + 1;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    phase_t           phase;
    logic [CNT_W-1:0] period_len;
    logic [CNT_W-1:0] cnt;
    logic             wrap;
    logic             seq_clear;

    // Return the period list to the start when idle is forced.
    always_comb begin
        seq_clear = !enable || frame_stop;
    end

    mir_phase_seq #(
        .CNT_W      (CNT_W),
        .FAST_BASE  (FAST_BASE),
        .FAST_EXTRA (FAST_EXTRA),
        .SLOW_BASE  (SLOW_BASE),
        .SLOW_EXTRA (SLOW_EXTRA)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (seq_clear),
        .restart    (frame_anchor),
        .advance    (wrap),
        .rate_slow  (rate_slow),
        .phase      (phase),
        .period_len (period_len)
    );

    mir_bit_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .anchor     (frame_anchor),
        .stop       (frame_stop),
        .period_len (period_len),
        .active     (active),
        .cnt        (cnt),
        .wrap       (wrap)
    );

    mir_pulse_gen #(
        .CNT_W   (CNT_W),
        .FAST_PW (FAST_PW),
        .SLOW_PW (SLOW_PW)
    ) u_pulse (
        .clk           (clk),
        .rst_n         (rst_n),
        .active        (active),
        .tx_mode       (tx_mode),
        .rate_slow     (rate_slow),
        .cnt           (cnt),
        .period_len    (period_len),
        .tx_bit        (tx_bit),
        .bit_strobe    (bit_strobe),
        .ir_pulse      (ir_pulse),
        .sample_strobe (sample_strobe)
    );

    // R9: outputs stay quiet whenever timing is not running.
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (!bit_strobe && !ir_pulse && !sample_strobe));

    // R7: stop wins over a simultaneous anchor.
    p_stop_over_anchor_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stop && frame_anchor) |=> !active);

    // R8: re-anchoring while running restarts at the first list entry.
    p_resync_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && active && frame_anchor && !frame_stop) |=> (phase == '0 && cnt == '0));
endmodule

// File: tb/mir_bit_clock_bench.sv
module mir_bit_clock_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic rate_slow = 1'b0;
    logic tx_mode = 1'b0;
    logic frame_anchor = 1'b0;
    logic frame_stop = 1'b0;
    logic tx_bit = 1'b1;
    logic active, bit_strobe, ir_pulse, sample_strobe;

    int checks = 0;
    int passed = 0;

    always #10 clk = ~clk;

    mir_bit_clock u_mir_bit_clock (
        .clk (clk), .rst_n (rst_n), .enable (enable), .rate_slow (rate_slow),
        .tx_mode (tx_mode), .frame_anchor (frame_anchor), .frame_stop (frame_stop),
        .tx_bit (tx_bit), .active (active), .bit_strobe (bit_strobe),
        .ir_pulse (ir_pulse), .sample_strobe (sample_strobe)
    );

    // Vector: {rate_slow, tx_mode, 8 line bits sent first-to-last from MSB}
    localparam int NVEC = 6;
    localparam logic [9:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 8'b0101_0011},
        {1'b0, 1'b1, 8'b0000_0000},
        {1'b1, 1'b1, 8'b1100_1010},
        {1'b1, 1'b1, 8'b1111_1111},
        {1'b0, 1'b0, 8'b0110_1001},
        {1'b1, 1'b0, 8'b1010_0101}
    };

    function automatic int plen(input logic slow, input int ph);
        if (slow) return (ph == 0) ? 84 : 83;
        return (ph == 1) ? 41 : 42;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (ok) passed++;
        else $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic anchor_now();
        frame_anchor = 1'b1;
        @(negedge clk);
        frame_anchor = 1'b0;
        #1;
    endtask

    task automatic stop_now();
        frame_stop = 1'b1;
        @(negedge clk);
        frame_stop = 1'b0;
        #1;
    endtask

    // Compare bit_strobe against the model for n cycles from an anchor (cycle 0 now).
    task automatic spacing(input string req, input int n);
        int off = 0;
        int ph = 0;
        int bad = 0;
        int bad_k = -1;
        for (int k = 0; k < n; k++) begin
            if (bit_strobe !== (off == 0)) begin
                bad++;
                if (bad_k < 0) bad_k = k;
            end
            off++;
            if (off == plen(rate_slow, ph)) begin
                off = 0;
                ph = (ph + 1) % 3;
            end
            step();
        end
        chk(bad == 0, req, "strobe spacing mismatches (first at cycle)", bad_k, -1);
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        #4000000;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", passed, checks);
        $finish;
    end

    initial begin
        // Reset state
        repeat (3) @(negedge clk);
        #1;
        chk(!active && !bit_strobe && !ir_pulse && !sample_strobe, "R1",
            "outputs in reset", int'({active, bit_strobe, ir_pulse, sample_strobe}), 0);
        rst_n = 1'b1;
        step();
        chk(!active, "R9", "active before anchor", int'(active), 0);
        enable = 1'b1;

        // Table of vectors walked by one loop
        for (int v = 0; v < NVEC; v++) begin
            int off = 0;
            int ph = 0;
            int bidx = 0;
            int e_str = 0, e_pls = 0, e_smp = 0, e_act = 0;
            logic [7:0] bits;
            bit first_ok;
            int pw;
            rate_slow = VEC[v][9];
            tx_mode   = VEC[v][8];
            bits      = VEC[v][7:0];
            pw        = rate_slow ? 21 : 10;
            @(negedge clk);
            tx_bit = bits[7];
            anchor_now();
            first_ok = tx_mode ? (bit_strobe === 1'b1) : (bit_strobe === 1'b0);
            chk(first_ok && active, "R4", "strobe at anchor cycle",
                int'(bit_strobe), int'(tx_mode));
            while (bidx < 8) begin
                logic zb;
                int l;
                tx_bit = bits[7 - bidx];
                #1;
                zb = !bits[7 - bidx];
                l  = plen(rate_slow, ph);
                if (bit_strobe !== (tx_mode && off == 0)) e_str++;
                if (ir_pulse !== (tx_mode && zb && off < pw)) e_pls++;
                if (sample_strobe !== (!tx_mode && off == l / 2)) e_smp++;
                if (active !== 1'b1) e_act++;
                off++;
                if (off == l) begin
                    off = 0;
                    ph = (ph + 1) % 3;
                    bidx++;
                end
                @(negedge clk);
            end
            chk(e_str == 0, rate_slow ? "R3" : "R2", "bit strobe mismatches", e_str, 0);
            chk(e_pls == 0, "R5", "pulse gate mismatches", e_pls, 0);
            chk(e_smp == 0, "R6", "sample strobe mismatches", e_smp, 0);
            chk(e_act == 0, "R9", "active dropped mid-frame", e_act, 0);
            stop_now();
            begin
                int noisy = 0;
                for (int k = 0; k < 100; k++) begin
                    if (active || bit_strobe || ir_pulse || sample_strobe) noisy++;
                    step();
                end
                chk(noisy == 0, "R7", "activity after stop", noisy, 0);
            end
        end

        // R7: stop and anchor on the same edge
        rate_slow = 1'b0;
        tx_mode   = 1'b1;
        frame_stop = 1'b1;
        anchor_now();
        frame_stop = 1'b0;
        chk(!active && !bit_strobe, "R7", "stop over anchor",
            int'({active, bit_strobe}), 0);

        // R8: re-anchor mid-run restarts the period list
        anchor_now();
        repeat (50) step();
        anchor_now();
        spacing("R8", 170);
        stop_now();

        // R1: dropping enable clears everything; enable alone does not restart
        anchor_now();
        repeat (30) step();
        enable = 1'b0;
        step();
        chk(!active && !bit_strobe && !ir_pulse, "R1", "idle after enable drop",
            int'({active, bit_strobe, ir_pulse}), 0);
        enable = 1'b1;
        begin
            int noisy = 0;
            for (int k = 0; k < 60; k++) begin
                if (active || bit_strobe || ir_pulse) noisy++;
                step();
            end
            chk(noisy == 0, "R1", "activity with enable but no anchor", noisy, 0);
        end
        anchor_now();
        spacing("R1", 170);
        stop_now();

        // R3: slow spacing after a restart
        rate_slow = 1'b1;
        anchor_now();
        spacing("R3", 300);
        stop_now();

        $display("%0d/%0d checks passed", passed, checks);
        $finish;
    end
endmodule